// File: doc/BRIEF.md
# Hidden Configuration Unlock for a Parallel ATA Host Port

This block sits between the host bus and the task-file registers of a parallel ATA host port. The configuration registers of the port have no address range of their own. They share the task-file offsets and stay hidden until software performs a fixed access sequence on the command block. The block watches every command-block access, which carries an offset, a read/write direction, a width flag (16-bit or byte) and write data. It then sends each access either on to the task-file register interface or into its own configuration registers.

The configuration registers hold a read-cycle timing byte and a write-cycle timing byte for each of the two drives, one address-setup byte that both drives share, a control byte, a strap byte and a drive select. When the control byte enables the override, the block gives the downstream PIO timing engine the programmed timing for the drive that engine names. Otherwise it gives the strapped defaults. A separate readback path returns the clock-speed strap pin.

Top module: `trapdoor_cfg`

## Requirements
- R1: After reset the block is locked (`cfg_open`=0), the override is off, the drive select is 0, and for either drive the timing outputs carry the defaults `DEF_RD`, `DEF_WR` and `DEF_ADDR`.
- R2: Three accesses in a row open the configuration space: a 16-bit read of offset 1, a second 16-bit read of offset 1, then a byte write of 0x03 to offset 2. `cfg_open` is 1 from the cycle after the byte write. All three accesses are still forwarded to the task file.
- R3: Any access that is not the next expected step of the unlock sequence sends the detector back to its start. This includes a third read of offset 1, a byte-wide read of offset 1, and any access to another offset. The block then stays locked.
- R4: While the block is locked, every access is forwarded unchanged on the `tf_*` outputs and changes no configuration register. The only exception is the armed strap read of R10.
- R5: While the block is open, byte writes to offsets 0, 1, 3, 5 and 6 go into configuration registers and are not forwarded. All other accesses, including 16-bit reads and byte writes to offsets 2 (other than 0x83), 4 and 7, are forwarded.
- R6: While the block is open, a byte write of 0x83 to offset 2 is not forwarded and locks the block from the next cycle.
- R7: A byte written to offset 6 (miscellaneous) whose upper nibble is 0 sets the drive select to its bit 0. Any other value becomes the address-setup byte, which both drives share.
- R8: A byte written to offset 0 sets the read timing, and one written to offset 1 sets the write timing, of the drive currently selected. `act_dev` picks which drive's bytes appear on `rd_timing` and `wr_timing`.
- R9: The override is on exactly while the control register (offset 3) holds 0x85. With the override on, the timing outputs carry the programmed bytes. With it off, they carry the defaults.
- R10: After a byte write of 0xFF to offset 5, the very next access, if it is a 16-bit read of offset 5, is not forwarded and returns the `strap_clk` pin in bit 0 with zeros above it. Any other next access disarms the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Command-block access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | AW | Command-block offset |
| bus_wdata | input | DW | Write data (byte writes use bits 7:0) |
| bus_rdata | output | DW | Read data returned to the host |
| tf_valid | output | 1 | Access forwarded to the task-file registers |
| tf_write | output | 1 | Forwarded direction |
| tf_wide | output | 1 | Forwarded width |
| tf_addr | output | AW | Forwarded offset |
| tf_wdata | output | DW | Forwarded write data |
| tf_rdata | input | DW | Read data from the task-file registers |
| strap_clk | input | 1 | Clock-speed strap pin |
| act_dev | input | 1 | Drive the timing engine is serving |
| cfg_open | output | 1 | Configuration space unlocked |
| tim_override | output | 1 | Programmed timings in effect |
| rd_timing | output | 8 | Read data/recovery timing for `act_dev` |
| wr_timing | output | 8 | Write data/recovery timing for `act_dev` |
| addr_timing | output | 8 | Shared address-setup timing |

## Verification
The unlock detector is driven with the correct read-read-write key and with three broken variants: an extra read of offset 1, an access to another offset inserted in the middle, and a byte-wide read in place of a 16-bit one. Each variant fails at a different state of the detector. While the block is open, different drive-select values are used to program two distinct timing sets, so a write that lands on the wrong drive shows up on `act_dev`. Writes to the timing offsets made while the block is locked, before and after the open phase, show whether locking really protects the registers. Toggling the control byte between 0x85 and another value separates the programmed timings from the defaults. The strap readback is tried with both pin levels and also without arming, which separates interception from forwarding.

// File: rtl/trapdoor_cfg.sv
module trapdoor_cfg #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter logic [7:0] DEF_RD   = 8'h6B,
  parameter logic [7:0] DEF_WR   = 8'h6B,
  parameter logic [7:0] DEF_ADDR = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic          bus_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tf_valid,
  output logic          tf_write,
  output logic          tf_wide,
  output logic [AW-1:0] tf_addr,
  output logic [DW-1:0] tf_wdata,
  input  logic [DW-1:0] tf_rdata,
  input  logic          strap_clk,
  input  logic          act_dev,
  output logic          cfg_open,
  output logic          tim_override,
  output logic [7:0]    rd_timing,
  output logic [7:0]    wr_timing,
  output logic [7:0]    addr_timing
);
  localparam logic [AW-1:0] OFS_RDT  = AW'(0);
  localparam logic [AW-1:0] OFS_WRT  = AW'(1);
  localparam logic [AW-1:0] OFS_KEY  = AW'(2);
  localparam logic [AW-1:0] OFS_CTL  = AW'(3);
  localparam logic [AW-1:0] OFS_STRP = AW'(5);
  localparam logic [AW-1:0] OFS_MISC = AW'(6);
  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] CTL_OVR   = 8'h85;
  localparam logic [7:0] STRAP_ARM = 8'hFF;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO} seq_t;

  seq_t       seq_q;
  logic       open_q, armed_q, dsel_q;
  logic [7:0] rdt_q [2];
  logic [7:0] wrt_q [2];
  logic [7:0] aset_q, ctl_q, strap_q;

  logic [7:0] wb;
  logic rd16, wr8, tap_rd, key_open, key_close, strap_hit, cfg_sel, cfg_wr, swallow;

  assign wb        = bus_wdata[7:0];
  assign rd16      = bus_valid & ~bus_write & bus_wide;
  assign wr8       = bus_valid & bus_write & ~bus_wide;
  assign tap_rd    = rd16 && (bus_addr == OFS_WRT);
  assign key_open  = wr8 && (bus_addr == OFS_KEY) && (wb == KEY_OPEN);
  assign key_close = wr8 && (bus_addr == OFS_KEY) && (wb == KEY_CLOSE);
  assign strap_hit = armed_q && rd16 && (bus_addr == OFS_STRP);
  assign cfg_sel   = (bus_addr == OFS_RDT) || (bus_addr == OFS_WRT) || (bus_addr == OFS_CTL) ||
                     (bus_addr == OFS_STRP) || (bus_addr == OFS_MISC);
  assign cfg_wr    = open_q && wr8 && cfg_sel;
  assign swallow   = cfg_wr || (open_q && key_close) || strap_hit;

  assign tf_valid  = bus_valid & ~swallow;
  assign tf_write  = bus_write;
  assign tf_wide   = bus_wide;
  assign tf_addr   = bus_addr;
  assign tf_wdata  = bus_wdata;
  assign bus_rdata = strap_hit ? {{(DW-1){1'b0}}, strap_clk} : tf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= SQ_IDLE;
      open_q <= 1'b0;
    end else if (bus_valid) begin
      if (open_q) begin
        if (key_close) begin
          open_q <= 1'b0;
          seq_q  <= SQ_IDLE;
        end
      end else begin
        case (seq_q)
          SQ_IDLE: seq_q <= tap_rd ? SQ_ONE : SQ_IDLE;
          SQ_ONE:  seq_q <= tap_rd ? SQ_TWO : SQ_IDLE;
          default: begin
            seq_q <= SQ_IDLE;
            if (key_open) open_q <= 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (bus_valid) armed_q <= wr8 && (bus_addr == OFS_STRP) && (wb == STRAP_ARM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsel_q  <= 1'b0;
      aset_q  <= DEF_ADDR;
      ctl_q   <= 8'h00;
      strap_q <= 8'h00;
      for (int i = 0; i < 2; i++) begin
        rdt_q[i] <= DEF_RD;
        wrt_q[i] <= DEF_WR;
      end
    end else if (cfg_wr) begin
      case (bus_addr)
        OFS_RDT:  rdt_q[dsel_q] <= wb;
        OFS_WRT:  wrt_q[dsel_q] <= wb;
        OFS_CTL:  ctl_q <= wb;
        OFS_STRP: strap_q <= wb;
        default: begin
          if (wb[7:4] == 4'h0) dsel_q <= wb[0];
          else aset_q <= wb;
        end
      endcase
    end
  end

  assign cfg_open     = open_q;
  assign tim_override = (ctl_q == CTL_OVR);
  assign rd_timing    = tim_override ? rdt_q[act_dev] : DEF_RD;
  assign wr_timing    = tim_override ? wrt_q[act_dev] : DEF_WR;
  assign addr_timing  = tim_override ? aset_q : DEF_ADDR;
endmodule

module trapdoor_cfg_chk #(
  parameter int AW = 3,
  parameter int DW = 16,
  parameter logic [7:0] DEF_RD   = 8'h6B,
  parameter logic [7:0] DEF_WR   = 8'h6B,
  parameter logic [7:0] DEF_ADDR = 8'h30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          bus_wide,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          tf_valid,
  input logic          act_dev,
  input logic          cfg_open,
  input logic          tim_override,
  input logic [7:0]    rd_timing,
  input logic [7:0]    wr_timing,
  input logic [7:0]    addr_timing
);
  logic wr8_c, strap_rd_c;
  assign wr8_c      = bus_valid && bus_write && !bus_wide;
  assign strap_rd_c = bus_valid && !bus_write && bus_wide && (bus_addr == AW'(5));

  AST_LOCKED_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_valid && !strap_rd_c) |-> tf_valid);  // R4
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && !bus_valid) |=> ((act_dev != $past(act_dev)) ||
      ($stable(rd_timing) && $stable(wr_timing) && $stable(addr_timing))));  // R4
  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(wr8_c && bus_addr == AW'(2) && bus_wdata[7:0] == 8'h03));  // R2
  AST_CFG_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && wr8_c && (bus_addr == AW'(0) || bus_addr == AW'(1) || bus_addr == AW'(3) ||
      bus_addr == AW'(5) || bus_addr == AW'(6))) |-> !tf_valid);  // R5
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && wr8_c && bus_addr == AW'(2) && bus_wdata[7:0] == 8'h83) |=> !cfg_open);  // R6
  AST_DEFAULTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tim_override |-> (rd_timing == DEF_RD && wr_timing == DEF_WR && addr_timing == DEF_ADDR));  // R9
  AST_STRAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !tf_valid) |-> (bus_rdata[DW-1:1] == '0));  // R10
endmodule

bind trapdoor_cfg trapdoor_cfg_chk #(.AW(AW), .DW(DW), .DEF_RD(DEF_RD), .DEF_WR(DEF_WR),
  .DEF_ADDR(DEF_ADDR)) u_chk (.*);

// File: tb/trapdoor_cfg_bench.sv
module trapdoor_cfg_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, tf_wdata, tf_rdata;
  logic tf_valid, tf_write, tf_wide;
  logic [2:0] tf_addr;
  logic strap_clk = 1'b0, act_dev = 1'b0;
  logic cfg_open, tim_override;
  logic [7:0] rd_timing, wr_timing, addr_timing;
  logic probe = 1'b0;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  bit kind_q[$];
  string req_q[$];

  always #(CLK_NS/2) clk = ~clk;
  assign tf_rdata = 16'hBE00 | {13'd0, tf_addr};

  trapdoor_cfg u_trapdoor_cfg (.*);

  task automatic acc(input logic w, input logic wide, input logic [2:0] a, input logic [15:0] d,
                     input logic fwd, input logic [15:0] rexp, input string req);
    bus_valid = 1'b1; bus_write = w; bus_wide = wide; bus_addr = a; bus_wdata = d;
    exp_q.push_back({14'd0, fwd, ~w, rexp}); kind_q.push_back(1'b0); req_q.push_back(req);
    @(posedge clk); #1 bus_valid = 1'b0;
  endtask

  task automatic tread(input logic [2:0] a, input logic fwd, input logic [15:0] rexp, input string req);
    acc(1'b0, 1'b1, a, 16'h0000, fwd, rexp, req);
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [7:0] d, input logic fwd, input string req);
    acc(1'b1, 1'b0, a, {8'h00, d}, fwd, 16'h0000, req);
  endtask

  task automatic chk(input logic dev, input logic op, input logic ovr, input logic [7:0] r,
                     input logic [7:0] w, input logic [7:0] ad, input string req);
    act_dev = dev; probe = 1'b1;
    exp_q.push_back({6'd0, op, ovr, r, w, ad}); kind_q.push_back(1'b1); req_q.push_back(req);
    @(posedge clk); #1 probe = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (probe || bus_valid)) begin
      logic [31:0] e, g;
      bit k;
      string rq;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard empty: got an event with no expected item");
      end else begin
        e = exp_q.pop_front(); k = kind_q.pop_front(); rq = req_q.pop_front();
        if (k) g = {6'd0, cfg_open, tim_override, rd_timing, wr_timing, addr_timing};
        else begin
          g = {14'd0, tf_valid, e[16], e[16] ? bus_rdata : 16'h0000};
          if (tf_valid && (tf_addr != bus_addr || tf_wdata != bus_wdata ||
              tf_write != bus_write || tf_wide != bus_wide)) g[31] = 1'b1;
        end
        compared++;
        if (g != e) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", rq, g, e);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(1'b0, 1'b0, 1'b0, 8'h6B, 8'h6B, 8'h30, "R1 reset dev0");
    chk(1'b1, 1'b0, 1'b0, 8'h6B, 8'h6B, 8'h30, "R1 reset dev1");
    // R10 strap readback
    strap_clk = 1'b1;
    bwrite(3'd5, 8'hFF, 1'b1, "R10 arm forwarded while locked");
    tread(3'd5, 1'b0, 16'h0001, "R10 strap high");
    strap_clk = 1'b0;
    bwrite(3'd5, 8'hFF, 1'b1, "R10 arm again");
    tread(3'd5, 1'b0, 16'h0000, "R10 strap low");
    tread(3'd5, 1'b1, 16'hBE05, "R10 unarmed read forwarded");
    bwrite(3'd5, 8'hFF, 1'b1, "R10 arm then disarm");
    tread(3'd4, 1'b1, 16'hBE04, "R10 other access");
    tread(3'd5, 1'b1, 16'hBE05, "R10 disarmed read forwarded");
    // R4 locked writes to timing offsets
    bwrite(3'd0, 8'h21, 1'b1, "R4 locked write offset 0");
    bwrite(3'd6, 8'h01, 1'b1, "R4 locked write offset 6");
    bwrite(3'd3, 8'h85, 1'b1, "R4 locked write offset 3");
    chk(1'b0, 1'b0, 1'b0, 8'h6B, 8'h6B, 8'h30, "R4 locked ctrl untouched");
    // R3 broken sequences
    tread(3'd1, 1'b1, 16'hBE01, "R3 rd a");
    tread(3'd1, 1'b1, 16'hBE01, "R3 rd b");
    tread(3'd1, 1'b1, 16'hBE01, "R3 rd c extra");
    bwrite(3'd2, 8'h03, 1'b1, "R3 key after extra read");
    chk(1'b0, 1'b0, 1'b0, 8'h6B, 8'h6B, 8'h30, "R3 still locked after extra read");
    tread(3'd1, 1'b1, 16'hBE01, "R3 rd d");
    tread(3'd7, 1'b1, 16'hBE07, "R3 interloper");
    tread(3'd1, 1'b1, 16'hBE01, "R3 rd e");
    bwrite(3'd2, 8'h03, 1'b1, "R3 key after interloper");
    chk(1'b0, 1'b0, 1'b0, 8'h6B, 8'h6B, 8'h30, "R3 still locked after interloper");
    acc(1'b0, 1'b0, 3'd1, 16'h0, 1'b1, 16'hBE01, "R3 byte read");
    tread(3'd1, 1'b1, 16'hBE01, "R3 rd f");
    bwrite(3'd2, 8'h03, 1'b1, "R3 key after byte read");
    chk(1'b0, 1'b0, 1'b0, 8'h6B, 8'h6B, 8'h30, "R3 still locked after byte read");
    // R2 correct key
    tread(3'd1, 1'b1, 16'hBE01, "R2 rd 1");
    tread(3'd1, 1'b1, 16'hBE01, "R2 rd 2");
    bwrite(3'd2, 8'h03, 1'b1, "R2 key forwarded");
    chk(1'b0, 1'b1, 1'b0, 8'h6B, 8'h6B, 8'h30, "R2 open");
    // R5 R7 R8 programming
    bwrite(3'd6, 8'h00, 1'b0, "R7 select drive 0");
    bwrite(3'd0, 8'h58, 1'b0, "R8 rd timing dev0");
    bwrite(3'd1, 8'h44, 1'b0, "R8 wr timing dev0");
    bwrite(3'd6, 8'h01, 1'b0, "R7 select drive 1");
    bwrite(3'd0, 8'h32, 1'b0, "R8 rd timing dev1");
    bwrite(3'd1, 8'h22, 1'b0, "R8 wr timing dev1");
    bwrite(3'd6, 8'h20, 1'b0, "R7 address setup");
    tread(3'd0, 1'b1, 16'hBE00, "R5 open read forwarded");
    bwrite(3'd4, 8'h11, 1'b1, "R5 offset 4 forwarded");
    bwrite(3'd2, 8'h55, 1'b1, "R5 offset 2 non-key forwarded");
    chk(1'b0, 1'b1, 1'b0, 8'h6B, 8'h6B, 8'h30, "R9 before override");
    bwrite(3'd3, 8'h85, 1'b0, "R9 override on");
    chk(1'b0, 1'b1, 1'b1, 8'h58, 8'h44, 8'h20, "R8 dev0 programmed");
    chk(1'b1, 1'b1, 1'b1, 8'h32, 8'h22, 8'h20, "R8 dev1 programmed");
    bwrite(3'd3, 8'h84, 1'b0, "R9 override off");
    chk(1'b0, 1'b1, 1'b0, 8'h6B, 8'h6B, 8'h30, "R9 defaults back");
    bwrite(3'd3, 8'h85, 1'b0, "R9 override on again");
    // R6 relock
    bwrite(3'd2, 8'h83, 1'b0, "R6 relock swallowed");
    chk(1'b0, 1'b0, 1'b1, 8'h58, 8'h44, 8'h20, "R6 locked, timings kept");
    bwrite(3'd0, 8'h10, 1'b1, "R4 locked write after relock");
    bwrite(3'd6, 8'h30, 1'b1, "R4 locked misc after relock");
    chk(1'b0, 1'b0, 1'b1, 8'h58, 8'h44, 8'h20, "R4 timings unchanged");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule